// File: doc/BRIEF.md
# Programmable AND-OR Logic Array

This block is the reconfigurable core of a small programmable logic device. It takes twelve dedicated inputs and ten feedback inputs and forms a true and a complement line from each, giving 44 lines. From these lines it evaluates 132 product terms. Each term is the AND of every line whose connection bit is set. A fixed OR structure then gathers groups of terms into ten sum outputs. The groups have unequal sizes that are mirrored about the centre of the array. Besides the sums, the block exports one output-enable term per output, a global synchronous-preset term and a global asynchronous-clear term. Registers, polarity and tristate control live downstream and are outside this block.

The connection pattern is loaded serially, one bit per clock while a load strobe is high, into a staging register. It reaches the evaluated array only on the edge that shifts in the final bit. A bulk-erase command opens every connection. With all connections open, every term reads TRUE. Term evaluation is combinational from the current inputs and the active pattern.

Top module: `pal_array`

## Requirements
- R1: The load stream fills bit k into term k/44, line k%44, starting from term 0, line 0. Line 2i is dedicated input i true and line 2i+1 is its complement (i = 0..11). Line 24+2j is feedback input j true and line 25+2j is its complement (j = 0..9).
- R2: A connection bit of 1 connects its line to the term. A term is TRUE exactly when all of its connected lines are 1.
- R3: A term with no connection bits set evaluates TRUE whatever the inputs.
- R4: A term connected to both the true and the complement line of one signal always evaluates FALSE and never raises its sum.
- R5: Sum output j is the OR of a run of consecutive terms. The run sizes for j = 0..9 are 8, 10, 12, 14, 16, 16, 14, 12, 10, 8, starting at term 0, and each run begins where the previous one ends.
- R6: Terms 120 to 129 drive output-enable bits 0 to 9. Term 130 drives the synchronous-preset output and term 131 drives the asynchronous-clear output.
- R7: A new pattern reaches the outputs on the clock edge that shifts in bit 5807. Before that edge the outputs follow the previous pattern.
- R8: Erase, sampled on a clock edge, opens every active and staged connection and returns the load position to bit 0. Erase overrides a simultaneous load.
- R9: A synchronous active-low reset leaves the array erased, so all outputs read 1, and returns the load position to bit 0.
- R10: While the load strobe is low, the data input has no effect, and the load position and active pattern are held. A load that is interrupted continues where it stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the configuration logic |
| rst_n | input | 1 | Synchronous active-low reset |
| ded_in | input | 12 | Dedicated input signals |
| fb_in | input | 10 | Feedback or I/O input signals |
| cfg_load | input | 1 | Shift one configuration bit this cycle |
| cfg_bit | input | 1 | Serial configuration data |
| cfg_erase | input | 1 | Bulk erase of all connections |
| sum_out | output | 10 | Sum-of-products outputs |
| oe_term | output | 10 | Per-output enable terms |
| sync_preset | output | 1 | Global synchronous-preset term |
| async_clear | output | 1 | Global asynchronous-clear term |

## Verification
Sums and terms are combinational, so the bench changes inputs away from the clock edge and compares every output against its own model of the loaded pattern a little later in the same cycle. A pattern counts as active from the edge that shifts its 5808th bit. The bench drives that bit, waits for that edge and checks at the next falling edge. It also checks one cycle earlier, with one bit still missing, that the old pattern still holds. Erase and reset act on the next edge, so their all-ones result is checked at the falling edge after it, and so are the outputs during a paused load.

// File: rtl/pal_pkg.sv
// Package: shared sizing and grouping functions for the AND-OR array.
// Assumes an even number of sums; the run sizes grow by two towards the
// array centre and shrink again, starting from a base size.
package pal_pkg;

    // Size of sum run j for a mirrored pattern of num_sums runs.
    function automatic int grp_size(input int j, input int num_sums, input int base);
        int d;
        d = (j < num_sums - 1 - j) ? j : num_sums - 1 - j;
        return base + 2 * d;
    endfunction

    // First term index of sum run j.
    function automatic int grp_off(input int j, input int num_sums, input int base);
        int acc;
        acc = 0;
        for (int k = 0; k < j; k++) acc += grp_size(k, num_sums, base);
        return acc;
    endfunction

    // Total number of terms that feed the sums.
    function automatic int sum_terms(input int num_sums, input int base);
        return grp_off(num_sums, num_sums, base);
    endfunction

endpackage

// File: rtl/pal_cfg_store.sv
// Module: serial configuration store with staging and active copies.
// Bits shift in at the top of the staging register, so the first bit
// ends at index 0. The active copy changes only on the completing edge
// or on erase or reset. Assumes erase has priority over load.
module pal_cfg_store #(
    parameter int CFG_BITS = 5808
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load,
    input  logic                bit_in,
    input  logic                erase,
    output logic [CFG_BITS-1:0] cfg_q
);
    localparam int CW = $clog2(CFG_BITS);
    localparam logic [CW-1:0] LAST = CW'(CFG_BITS - 1);

    logic [CFG_BITS-1:0] stage_q;
    logic [CFG_BITS-1:0] active_q;
    logic [CW-1:0]       pos_q;
    logic [CFG_BITS-1:0] stage_nx;

    // Next staging value with the incoming bit at the top.
    always_comb stage_nx = {bit_in, stage_q[CFG_BITS-1:1]};

    // Shift, count and commit the configuration.
    always_ff @(posedge clk) begin
        if (!rst_n || erase) begin
            stage_q  <= '0;
            active_q <= '0;
            pos_q    <= '0;
        end else if (load) begin
            stage_q <= stage_nx;
            if (pos_q == LAST) begin
                active_q <= stage_nx;
                pos_q    <= '0;
            end else begin
                pos_q <= pos_q + 1'b1;
            end
        end
    end

    assign cfg_q = active_q;

    // R8: erase empties the store and rewinds the position
    a_r8_erase_clears: assert property (@(posedge clk) disable iff (!rst_n)
        erase |=> (pos_q == '0) && (active_q == '0) && (stage_q == '0));

    // R7: the active pattern moves only on the completing edge
    a_r7_hold_until_done: assert property (@(posedge clk) disable iff (!rst_n)
        (!erase && !(load && pos_q == LAST)) |=> $stable(active_q));

    // R7: the position wraps after the final bit
    a_r7_pos_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (!erase && load && pos_q == LAST) |=> pos_q == '0);

    // R10: an idle load strobe freezes the position
    a_r10_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!erase && !load) |=> $stable(pos_q) && $stable(stage_q));

    // R1: position never passes the last bit
    a_r1_pos_range: assert property (@(posedge clk) disable iff (!rst_n)
        pos_q <= LAST);

endmodule

// File: rtl/pal_term_eval.sv
// Module: builds the true/complement lines and evaluates every product term.
// A set connection bit requires its line to be 1. Open bits are ignored,
// so an all-open term reads TRUE. Purely combinational.
module pal_term_eval #(
    parameter int NUM_DED   = 12,
    parameter int NUM_FB    = 10,
    parameter int NUM_TERMS = 132,
    localparam int LINES    = 2 * (NUM_DED + NUM_FB),
    localparam int CFG_BITS = NUM_TERMS * LINES
) (
    input  logic [NUM_DED-1:0]   ded_in,
    input  logic [NUM_FB-1:0]    fb_in,
    input  logic [CFG_BITS-1:0]  cfg,
    output logic [NUM_TERMS-1:0] terms
);
    logic [LINES-1:0] lines;

    // Dedicated input lines, true then complement.
    for (genvar i = 0; i < NUM_DED; i++) begin : g_ded
        assign lines[2*i]   = ded_in[i];
        assign lines[2*i+1] = ~ded_in[i];
    end

    // Feedback lines, following the dedicated ones.
    for (genvar j = 0; j < NUM_FB; j++) begin : g_fb
        assign lines[2*NUM_DED+2*j]   = fb_in[j];
        assign lines[2*NUM_DED+2*j+1] = ~fb_in[j];
    end

    // One wide AND per term over its connected lines.
    for (genvar t = 0; t < NUM_TERMS; t++) begin : g_term
        assign terms[t] = &(~cfg[t*LINES +: LINES] | lines);
    end

endmodule

// File: rtl/pal_sum_or.sv
// Module: fixed OR grouping of terms into sums plus the special terms.
// Runs follow the mirrored size pattern from the package. After the sum
// terms come one enable term per output, then preset, then clear.
module pal_sum_or #(
    parameter int NUM_SUMS   = 10,
    parameter int BASE_SIZE  = 8,
    localparam int SUMT      = pal_pkg::sum_terms(NUM_SUMS, BASE_SIZE),
    localparam int NUM_TERMS = SUMT + NUM_SUMS + 2
) (
    input  logic [NUM_TERMS-1:0] terms,
    output logic [NUM_SUMS-1:0]  sums,
    output logic [NUM_SUMS-1:0]  oe,
    output logic                 preset,
    output logic                 clear
);
    // One OR per sum over its run of terms.
    for (genvar j = 0; j < NUM_SUMS; j++) begin : g_sum
        localparam int OFF = pal_pkg::grp_off(j, NUM_SUMS, BASE_SIZE);
        localparam int SZ  = pal_pkg::grp_size(j, NUM_SUMS, BASE_SIZE);
        assign sums[j] = |terms[OFF +: SZ];
    end

    // Special terms pass straight through.
    assign oe     = terms[SUMT +: NUM_SUMS];
    assign preset = terms[SUMT + NUM_SUMS];
    assign clear  = terms[SUMT + NUM_SUMS + 1];

endmodule

// File: rtl/pal_array.sv
// Module: top of the programmable AND-OR array.
// It joins the configuration store, the term evaluator and the OR
// grouping. Assumes the feedback count equals the number of sums.
module pal_array #(
    parameter int NUM_DED   = 12,
    parameter int NUM_FB    = 10,
    parameter int BASE_SIZE = 8,
    localparam int LINES     = 2 * (NUM_DED + NUM_FB),
    localparam int SUMT      = pal_pkg::sum_terms(NUM_FB, BASE_SIZE),
    localparam int NUM_TERMS = SUMT + NUM_FB + 2,
    localparam int CFG_BITS  = NUM_TERMS * LINES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_DED-1:0] ded_in,
    input  logic [NUM_FB-1:0]  fb_in,
    input  logic              cfg_load,
    input  logic              cfg_bit,
    input  logic              cfg_erase,
    output logic [NUM_FB-1:0]  sum_out,
    output logic [NUM_FB-1:0]  oe_term,
    output logic              sync_preset,
    output logic              async_clear
);
    logic [CFG_BITS-1:0]  cfg;
    logic [NUM_TERMS-1:0] terms;

    pal_cfg_store #(.CFG_BITS(CFG_BITS)) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (cfg_load),
        .bit_in (cfg_bit),
        .erase  (cfg_erase),
        .cfg_q  (cfg)
    );

    pal_term_eval #(.NUM_DED(NUM_DED), .NUM_FB(NUM_FB), .NUM_TERMS(NUM_TERMS)) u_eval (
        .ded_in (ded_in),
        .fb_in  (fb_in),
        .cfg    (cfg),
        .terms  (terms)
    );

    pal_sum_or #(.NUM_SUMS(NUM_FB), .BASE_SIZE(BASE_SIZE)) u_or (
        .terms  (terms),
        .sums   (sum_out),
        .oe     (oe_term),
        .preset (sync_preset),
        .clear  (async_clear)
    );

    // R3: after erase every open term, and so every output, reads 1
    a_r3_erased_all_true: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_erase |=> (&sum_out) && (&oe_term) && sync_preset && async_clear);

    // R9: leaving reset shows the erased array
    a_r9_reset_erased: assert property (@(posedge clk)
        (!rst_n) |=> (&sum_out) && (&oe_term) && sync_preset && async_clear);

endmodule

// File: tb/sim_pal_array.sv
// Bench: directed scenarios for the AND-OR array against a bench-side model.
module sim_pal_array;
    localparam int PERIOD = 10;
    localparam int NT = 132;
    localparam int NL = 44;
    localparam int NB = NT * NL;
    localparam int SZ [10] = '{8, 10, 12, 14, 16, 16, 14, 12, 10, 8};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [11:0] ded_in = '0;
    logic [9:0]  fb_in = '0;
    logic cfg_load = 1'b0, cfg_bit = 1'b0, cfg_erase = 1'b0;
    logic [9:0] sum_out, oe_term;
    logic sync_preset, async_clear;

    int checks = 0;
    int errors = 0;

    logic [NL-1:0] bcfg [NT];
    logic [NL-1:0] mcfg [NT];

    pal_array u0 (
        .clk(clk), .rst_n(rst_n), .ded_in(ded_in), .fb_in(fb_in),
        .cfg_load(cfg_load), .cfg_bit(cfg_bit), .cfg_erase(cfg_erase),
        .sum_out(sum_out), .oe_term(oe_term),
        .sync_preset(sync_preset), .async_clear(async_clear)
    );

    always #(PERIOD/2) clk = ~clk;

    function automatic logic line_val(int l);
        if (l < 24) return ded_in[l/2] ^ logic'(l % 2);
        return fb_in[(l-24)/2] ^ logic'(l % 2);
    endfunction

    function automatic logic term_val(int t);
        logic v = 1'b1;
        for (int l = 0; l < NL; l++) if (mcfg[t][l] && !line_val(l)) v = 1'b0;
        return v;
    endfunction

    task automatic check_now(string tag);
        logic [9:0] es, eo;
        logic ep, ec;
        int off = 0;
        for (int j = 0; j < 10; j++) begin
            es[j] = 1'b0;
            for (int k = 0; k < SZ[j]; k++) es[j] |= term_val(off + k);
            off += SZ[j];
            eo[j] = term_val(120 + j);
        end
        ep = term_val(130);
        ec = term_val(131);
        checks++;
        if (sum_out !== es || oe_term !== eo || sync_preset !== ep || async_clear !== ec) begin
            errors++;
            $display("FAIL %s: got sum=%b oe=%b p=%b c=%b expected sum=%b oe=%b p=%b c=%b",
                     tag, sum_out, oe_term, sync_preset, async_clear, es, eo, ep, ec);
        end
    endtask

    // Drive several input vectors and check each.
    task automatic check_inputs(string tag, int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            ded_in = 12'($urandom);
            fb_in  = 10'($urandom);
            #1 check_now(tag);
        end
    endtask

    task automatic clear_model();
        for (int t = 0; t < NT; t++) mcfg[t] = '0;
    endtask

    // Build a pattern in bcfg: every term killed, then chosen terms set.
    task automatic build(int mode);
        int off = 0;
        for (int t = 0; t < NT; t++) bcfg[t] = 44'b11;
        for (int j = 0; j < 10; j++) begin
            int t = (mode == 0) ? off + SZ[j] - 1 : off;
            bcfg[t] = '0;
            if (mode == 0) begin
                bcfg[t][2*j] = 1'b1;
                bcfg[t][24 + 2*((j+3)%10) + 1] = 1'b1;
            end else begin
                bcfg[t][2*(j+2) + 1] = 1'b1;
                bcfg[t][24 + 2*j] = 1'b1;
            end
            off += SZ[j];
            bcfg[120+j] = '0;
            bcfg[120+j][24 + 2*j + mode] = 1'b1;
        end
        bcfg[130] = '0;
        bcfg[130][22] = 1'b1;
        bcfg[130][20] = 1'b1;
        bcfg[131] = '0;
        if (mode == 1) bcfg[131][1] = 1'b1;
    endtask

    task automatic stream(int from, int upto);
        for (int k = from; k < upto; k++) begin
            @(negedge clk);
            cfg_load = 1'b1;
            cfg_bit  = bcfg[k/NL][k%NL];
        end
        @(negedge clk);
        cfg_load = 1'b0;
        cfg_bit  = 1'b0;
    endtask

    task automatic commit();
        for (int t = 0; t < NT; t++) mcfg[t] = bcfg[t];
    endtask

    task automatic t_reset();
        clear_model();
        check_inputs("R9 reset erased", 4);
        check_inputs("R3 open terms true", 2);
    endtask

    task automatic t_pattern(int mode);
        build(mode);
        stream(0, NB);
        commit();
        check_inputs("R1 R2 R4 R5 R6 pattern", 12);
    endtask

    task automatic t_commit_edge();
        build(0);
        stream(0, NB - 1);
        #1 check_now("R7 old pattern before last bit");
        check_inputs("R7 old pattern before last bit", 3);
        stream(NB - 1, NB);
        commit();
        #1 check_now("R7 new pattern after last bit");
        check_inputs("R7 new pattern", 3);
    endtask

    task automatic t_pause();
        build(1);
        stream(0, 2000);
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            cfg_bit = logic'($urandom);
        end
        #1 check_now("R10 paused load no effect");
        stream(2000, NB);
        commit();
        check_inputs("R10 resumed load", 4);
    endtask

    task automatic t_erase();
        build(1);
        stream(0, 1500);
        @(negedge clk);
        cfg_load = 1'b1;
        cfg_bit  = 1'b1;
        cfg_erase = 1'b1;
        @(negedge clk);
        cfg_load = 1'b0;
        cfg_erase = 1'b0;
        clear_model();
        #1 check_now("R8 erase over load");
        check_inputs("R8 erased outputs", 3);
        build(0);
        stream(0, NB);
        commit();
        check_inputs("R8 position rewound", 4);
    endtask

    task automatic t_reset_again();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        clear_model();
        #1 check_now("R9 reset clears pattern");
        build(1);
        stream(0, NB);
        commit();
        check_inputs("R9 load after reset", 3);
    endtask

    initial begin
        #(PERIOD * 190000);
        errors++;
        checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_pattern(0);
        t_pattern(1);
        t_commit_edge();
        t_pause();
        t_erase();
        t_reset_again();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule